// File: doc/BRIEF.md
# Twelve-Line GPIO Controller with Latched Level Interrupts

This block is a memory-mapped general-purpose I/O peripheral serving a parameterized number of pins, twelve by default. Software reaches it over a plain 32-bit register port made of a word address, a write strobe, write data and combinational read data. It holds a pin output value, a per-pin drive enable, and a synchronized view of the pins. It also keeps a plain storage word for pin multiplexing that the surrounding chip decodes.

Every pin can raise a level-sensitive interrupt whose active level is chosen per pin. A pin seen at its active level sets a sticky status bit. Software clears that bit by writing a one to it. If the pin is still active, the bit sets again on the following cycle. A mask word selects which status bits reach the single combined interrupt output.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After reset, the output value, drive enable, mask, status, both polarity words and the mux word read as zero, and pin_oe and irq are low.
- R2: A write at byte offset 0x00 sets the output value and a write at 0x04 sets the drive enable. Both take effect on the next clock edge and read back with bits above NPINS-1 as zero. pin_out and pin_oe follow these registers.
- R3: A read at 0x08 returns each pin's level after two flip-flop stages. A change on a pin is visible there on the second rising edge after it is applied. Writes to 0x08 have no effect.
- R4: Pin n's polarity bit sits at bit 4*(n mod 8) of the word at 0x10 for pins 0 to 7, and of the word at 0x18 for pins 8 and up. A 0 selects active-high and a 1 selects active-low. Both words, and the mux word at 0x1C, store and read back all 32 written bits.
- R5: The status bit for pin n sets on the edge after the synchronized pin is at its active level, and it then stays set even after the pin goes inactive.
- R6: Writing to 0x0C clears exactly the status bits written as one. Bits written as zero are left unchanged.
- R7: If the synchronized pin is still active when its status bit is cleared, the bit reads set again one cycle later.
- R8: irq is high exactly when some pin has both its status bit and its mask bit (offset 0x14) set. Writing zero to the mask forces irq low while the status stays latched.
- R9: A read of any offset that is not one of the eight registers returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Value driven on each pin |
| pin_oe | output | NPINS | Drive enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default of twelve pins. At that width the polarity map reaches both type words, including pin 11 at bit 12 of the upper word. Bits 12 to 31 of the data registers can then be checked as reading zero. Random pin patterns and random polarity words are mixed with directed cases for re-latching after a clear, partial clears, and masking off irq with status still held.

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int NPINS = 12,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [AW-1:0] A_OUT = AW'(6'h00), A_OE = AW'(6'h04), A_IN = AW'(6'h08),
    A_STS = AW'(6'h0C), A_TLO = AW'(6'h10), A_MSK = AW'(6'h14), A_THI = AW'(6'h18),
    A_MUX = AW'(6'h1C);

  logic [NPINS-1:0] out_q, oe_q, msk_q, sts_q, s1_q, s2_q, pol, act;
  logic [31:0]      tlo_q, thi_q, mux_q;

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pol
      if (g < 8) begin : g_lo
        assign pol[g] = tlo_q[4*g];
      end else begin : g_hi
        assign pol[g] = thi_q[4*(g-8)];
      end
    end
  endgenerate

  assign act = s2_q ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0; oe_q <= '0; msk_q <= '0;
      tlo_q <= '0; thi_q <= '0; mux_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_OUT: out_q <= bus_wdata[NPINS-1:0];
        A_OE:  oe_q  <= bus_wdata[NPINS-1:0];
        A_MSK: msk_q <= bus_wdata[NPINS-1:0];
        A_TLO: tlo_q <= bus_wdata;
        A_THI: thi_q <= bus_wdata;
        A_MUX: mux_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  wire [NPINS-1:0] clr = (bus_we && bus_addr == A_STS) ? bus_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr) | act;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_OUT: bus_rdata[NPINS-1:0] = out_q;
      A_OE:  bus_rdata[NPINS-1:0] = oe_q;
      A_IN:  bus_rdata[NPINS-1:0] = s2_q;
      A_STS: bus_rdata[NPINS-1:0] = sts_q;
      A_MSK: bus_rdata[NPINS-1:0] = msk_q;
      A_TLO: bus_rdata = tlo_q;
      A_THI: bus_rdata = thi_q;
      A_MUX: bus_rdata = mux_q;
      default: ;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;
  assign irq     = |(sts_q & msk_q);

  // R5: an active synchronized pin always latches status on the next edge
  a_r5_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (act != '0) |=> ((sts_q & $past(act)) == $past(act)));
  // R6: status bits not written as one and not active do not change
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(clr) & ~$past(act)) == ($past(sts_q) & ~$past(clr) & ~$past(act))));
  // R8: no irq while mask is zero
  a_r8_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq);
  // R2: drive enable changes only through a bus write
  a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_OE) |=> $stable(pin_oe));
  // R3: input register follows the pins two edges later
  a_r3_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pin_in) |=> ##1 (s2_q == $past(pin_in, 2)));
endmodule

// File: tb/gpio_lvl_irq_test.sv
module gpio_lvl_irq_test;
  localparam int N = 12;
  logic clk = 0, rst_n = 0, we = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [N-1:0] pin = 0, pout, poe;
  logic irq;
  int checks = 0, errors = 0;
  logic [N-1:0] m_sts;

  gpio_lvl_irq uut (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pin), .pin_out(pout), .pin_oe(poe), .irq(irq));

  always #2.5 clk = ~clk;

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s act=%h exp=%h", r, act, exp); end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [N-1:0] activ(logic [N-1:0] p, logic [31:0] lo, logic [31:0] hi);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = p[i] ^ (i < 8 ? lo[4*i] : hi[4*(i-8)]);
    return r;
  endfunction

  initial begin
    logic [31:0] d, lo, hi;
    logic [N-1:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    foreach (uut.out_q[i]) ;
    rd(6'h00, d); chk("R1 out", d, 0);
    rd(6'h04, d); chk("R1 oe", d, 0);
    rd(6'h0C, d); chk("R1 sts", d, 0);
    rd(6'h14, d); chk("R1 msk", d, 0);
    rd(6'h10, d); chk("R1 tlo", d, 0);
    rd(6'h18, d); chk("R1 thi", d, 0);
    rd(6'h1C, d); chk("R1 mux", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pin_oe", {20'b0, poe}, 0);
    // R9
    rd(6'h20, d); chk("R9 unmapped", d, 0);
    // R2
    wr(6'h00, 32'hFFFF_FA5C); rd(6'h00, d); chk("R2 out rb", d, 32'h0000_0A5C);
    chk("R2 pin_out", {20'b0, pout}, 32'h0A5C);
    wr(6'h04, 32'h0000_0F0F); chk("R2 pin_oe", {20'b0, poe}, 32'h0F0F);
    // R4 full word storage
    wr(6'h10, 32'hDEAD_BEEE); rd(6'h10, d); chk("R4 tlo", d, 32'hDEAD_BEEE);
    wr(6'h18, 32'h1234_5670); rd(6'h18, d); chk("R4 thi", d, 32'h1234_5670);
    wr(6'h1C, 32'hCAFE_F00D); rd(6'h1C, d); chk("R4 mux", d, 32'hCAFE_F00D);
    wr(6'h10, 0); wr(6'h18, 0); wr(6'h0C, 32'hFFF);
    // R3 sync timing
    @(negedge clk); pin = 12'h0;
    repeat (3) @(negedge clk);
    wr(6'h0C, 32'hFFF);
    @(negedge clk); pin = 12'h801;
    @(negedge clk); addr = 6'h08; #1 chk("R3 after 1 edge", rdata, 0);
    @(negedge clk); #1 chk("R3 after 2 edges", rdata, 32'h801);
    wr(6'h08, 32'hFFF); rd(6'h08, d); chk("R3 write ignored", d, 32'h801);
    // R5 latch, stays after pin drop
    pin = 0; repeat (3) @(negedge clk);
    rd(6'h0C, d); chk("R5 sticky", d, 32'h801);
    // R6 partial clear
    wr(6'h0C, 32'h001); rd(6'h0C, d); chk("R6 partial", d, 32'h800);
    wr(6'h0C, 32'h800); rd(6'h0C, d); chk("R6 clear", d, 0);
    // R4 polarity: pin 11 active-low via bit 12 of upper word, pin 3 via bit 12 of lower
    wr(6'h18, 32'h0000_1000); wr(6'h10, 32'h0000_1000);
    repeat (3) @(negedge clk);
    rd(6'h0C, d); chk("R4 active-low latch", d, 32'h808);
    // R7 relatch while held active
    wr(6'h0C, 32'hFFF); rd(6'h0C, d); chk("R7 relatch", d, 32'h808);
    // R8
    wr(6'h14, 32'h008); chk("R8 irq on", {31'b0, irq}, 1);
    wr(6'h14, 0); chk("R8 mask off", {31'b0, irq}, 0);
    rd(6'h0C, d); chk("R8 status held", d, 32'h808);
    // random
    for (int k = 0; k < 40; k++) begin
      lo = $urandom; hi = $urandom;
      wr(6'h10, lo); wr(6'h18, hi);
      pin = N'($urandom);
      repeat (3) @(negedge clk);
      wr(6'h0C, 32'hFFF);
      a = activ(pin, lo, hi);
      rd(6'h0C, d); chk("R7 random relatch", d, {20'b0, a});
      rd(6'h08, d); chk("R3 random input", d, {20'b0, pin});
      m_sts = N'($urandom);
      wr(6'h14, {20'b0, m_sts});
      chk("R8 random irq", {31'b0, irq}, {31'b0, |(a & m_sts)});
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule